// File: doc/BRIEF.md
# Right Shifter with Lost-Bit Sticky Flag

This block is one registered stage of a floating-point datapath. It takes a 64-bit mantissa and a signed shift count. A negative count means a right shift by that many places. The stage returns the logically shifted mantissa on the next clock edge.

The stage also keeps an inexact flag that records whether any 1-bit dropped below the least-significant position. Loss detection does not build a mask. It negates the operand in two's complement and ORs the result with the operand itself. The result is all ones from the lowest set bit upward and all zeros below it. One bit of that word then answers whether the low N bits hold anything.

A long-window mode extends the tested window by 29 extra bits, so loss can be judged against a narrower target precision. The flag only collects new loss while the enable strobe is high. Between operations it is cleared by a dedicated input.

Top module: `shr_sticky_stage`

## Requirements
- R1: While `rst` is high at a clock edge, `q_out` becomes zero and `sticky_out` becomes 0 on that edge.
- R2: Both outputs are registered. The values presented at one rising edge appear on `q_out` and `sticky_out` after that edge, with one cycle of latency.
- R3: For a count of −N with N > 0, `q_out` is `r_in` logically shifted right by N with zeros filled in from the top. For N ≥ 64 the result is all zeros.
- R4: For a count of zero or more, `q_out` equals `r_in` unchanged. In normal mode such a count reports no lost bits.
- R5: In normal mode (`long_mode`=0), a count of −N with `sticky_en`=1 sets the flag if and only if any of bits N−1..0 of `r_in` is 1.
- R6: In long-window mode (`long_mode`=1), the tested window is the lowest 29−count bits of `r_in`. A count of 29 or more tests no bits and leaves the flag unchanged.
- R7: When the tested window is 64 bits or wider, any nonzero `r_in` sets the flag. A zero `r_in` never sets it.
- R8: Once set, `sticky_out` stays 1 until `clr` or `rst` is applied.
- R9: When `sticky_en` is 0, `sticky_out` is not changed by the bits lost in that cycle.
- R10: `clr`=1 discards the accumulated flag. The loss result of the same cycle, when enabled, is still ORed into the cleared value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| clr | input | 1 | Discards the accumulated sticky flag |
| r_in | input | 64 | Mantissa to be shifted |
| shift_in | input | 13 | Signed shift count; negative means right shift |
| sticky_en | input | 1 | Allows this cycle's loss result into the flag |
| long_mode | input | 1 | Widens the loss window by 29 bits |
| q_out | output | 64 | Registered shifted mantissa |
| sticky_out | output | 1 | Registered accumulated lost-bit flag |

## Verification
The bench aims at the edges of the loss window:
- A count of −1 against bit 0 versus bit 1. An off-by-one bit selection would flag the wrong one of these.
- Long-window counts of 28, 29 and 0. A missing 29-bit offset would miss bit 28 or flag bit 29.
- Counts of −64 and far below. A design without the clamp would wrap the index and drop the loss of a high lone bit.
- Non-negative counts, a zero operand, the enable held low and a clear that coincides with new loss. A design that ignores the sign, or sets the flag without its enable, or lets clear take priority over same-cycle loss, would differ at the flag.

Every result is compared with a mask-and-OR reference model.

// File: rtl/shr_pkg.sv
package shr_pkg;
  // Extra window bits added by the long-window mode
  localparam int unsigned LONG_EXTRA_BITS = 29;

  typedef enum logic {
    WIN_NORMAL = 1'b0,
    WIN_LONG   = 1'b1
  } win_mode_e;
endpackage

// File: rtl/shr_index_calc.sv
// Turns the signed shift count into the bit index to sample in R|-R.
module shr_index_calc #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 13,
  parameter int EXTRA_W = 29,
  localparam int SEL_W  = $clog2(DATA_W)
) (
  input  logic signed [CNT_W-1:0] shift_cnt,
  input  shr_pkg::win_mode_e      mode,
  output logic                    idx_valid,
  output logic [SEL_W-1:0]        idx
);
  localparam int IW = CNT_W + 2;

  logic signed [IW-1:0] base;
  logic signed [IW-1:0] cnt_x;
  logic signed [IW-1:0] raw;

  always_comb begin
    base  = (mode == shr_pkg::WIN_LONG) ? IW'(EXTRA_W - 1) : -IW'(1);
    cnt_x = IW'(shift_cnt);
    raw   = base - cnt_x;
    idx_valid = !raw[IW-1];
    if (raw >= IW'(DATA_W)) idx = SEL_W'(DATA_W - 1);
    else                    idx = raw[SEL_W-1:0];
  end
endmodule

// File: rtl/shr_lost_detect.sv
// Tests whether bits idx..0 of r hold a 1 by sampling bit idx of (r | -r).
module shr_lost_detect #(
  parameter int DATA_W = 64,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0] r,
  input  logic              idx_valid,
  input  logic [SEL_W-1:0]  idx,
  output logic              lost
);
  logic [DATA_W-1:0] r_or_neg;

  always_comb begin
    r_or_neg = r | (~r + DATA_W'(1));
    lost     = idx_valid & r_or_neg[idx];
  end
endmodule

// File: rtl/shr_barrel.sv
// Logarithmic logical right shifter driven by a signed count.
module shr_barrel #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 13,
  localparam int SEL_W = $clog2(DATA_W)
) (
  input  logic [DATA_W-1:0]       r,
  input  logic signed [CNT_W-1:0] shift_cnt,
  output logic [DATA_W-1:0]       q
);
  logic signed [CNT_W:0] cnt_x;
  logic [CNT_W:0]        mag;
  logic                  over;
  logic [DATA_W-1:0]     stg [0:SEL_W];

  always_comb begin
    cnt_x = (CNT_W+1)'(shift_cnt);
    mag   = cnt_x[CNT_W] ? (CNT_W+1)'(-cnt_x) : '0;
    over  = |mag[CNT_W:SEL_W];
  end

  assign stg[0] = r;

  for (genvar k = 0; k < SEL_W; k++) begin : g_stage
    assign stg[k+1] = mag[k] ? (stg[k] >> (1 << k)) : stg[k];
  end

  assign q = over ? '0 : stg[SEL_W];
endmodule

// File: rtl/shr_sticky_stage.sv
module shr_sticky_stage #(
  parameter int DATA_W  = 64,
  parameter int CNT_W   = 13,
  parameter int EXTRA_W = shr_pkg::LONG_EXTRA_BITS,
  localparam int SEL_W  = $clog2(DATA_W)
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    clr,
  input  logic [DATA_W-1:0]       r_in,
  input  logic signed [CNT_W-1:0] shift_in,
  input  logic                    sticky_en,
  input  logic                    long_mode,
  output logic [DATA_W-1:0]       q_out,
  output logic                    sticky_out
);
  shr_pkg::win_mode_e mode;
  logic               idx_valid;
  logic [SEL_W-1:0]   idx;
  logic               lost;
  logic [DATA_W-1:0]  shifted;
  logic               flag_nxt;

  assign mode = long_mode ? shr_pkg::WIN_LONG : shr_pkg::WIN_NORMAL;

  shr_index_calc #(.DATA_W(DATA_W), .CNT_W(CNT_W), .EXTRA_W(EXTRA_W)) u_idx (
    .shift_cnt(shift_in), .mode(mode), .idx_valid(idx_valid), .idx(idx)
  );

  shr_lost_detect #(.DATA_W(DATA_W)) u_lost (
    .r(r_in), .idx_valid(idx_valid), .idx(idx), .lost(lost)
  );

  shr_barrel #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_shift (
    .r(r_in), .shift_cnt(shift_in), .q(shifted)
  );

  assign flag_nxt = (sticky_out & ~clr) | (sticky_en & lost);

  always_ff @(posedge clk) begin
    if (rst) begin
      q_out      <= '0;
      sticky_out <= 1'b0;
    end else begin
      q_out      <= shifted;
      sticky_out <= flag_nxt;
    end
  end
endmodule

// File: rtl/shr_sticky_stage_chk.sv
module shr_sticky_stage_chk #(
  parameter int DATA_W = 64,
  parameter int CNT_W  = 13
) (
  input logic                    clk,
  input logic                    rst,
  input logic                    clr,
  input logic [DATA_W-1:0]       r_in,
  input logic signed [CNT_W-1:0] shift_in,
  input logic                    sticky_en,
  input logic                    long_mode,
  input logic [DATA_W-1:0]       q_out,
  input logic                    sticky_out
);
  a_r1_reset_clears: assert property (@(posedge clk)
    rst |=> (q_out == '0 && !sticky_out));

  a_r4_pass_through: assert property (@(posedge clk) disable iff (rst)
    (shift_in >= 0) |=> q_out == $past(r_in));

  a_r4_no_loss: assert property (@(posedge clk) disable iff (rst)
    (shift_in >= 0 && !long_mode && !clr) |=> $stable(sticky_out));

  a_r7_clamp_any_one: assert property (@(posedge clk) disable iff (rst)
    (sticky_en && r_in != '0 && shift_in <= -DATA_W) |=> sticky_out);

  a_r7_zero_operand: assert property (@(posedge clk) disable iff (rst)
    (r_in == '0 && !clr) |=> $stable(sticky_out));

  a_r8_sticky_holds: assert property (@(posedge clk) disable iff (rst)
    (sticky_out && !clr) |=> sticky_out);

  a_r9_enable_gate: assert property (@(posedge clk) disable iff (rst)
    (!sticky_en && !clr) |=> $stable(sticky_out));

  a_r10_clear: assert property (@(posedge clk) disable iff (rst)
    (clr && !sticky_en) |=> !sticky_out);
endmodule

bind shr_sticky_stage shr_sticky_stage_chk #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst(rst), .clr(clr), .r_in(r_in), .shift_in(shift_in),
  .sticky_en(sticky_en), .long_mode(long_mode), .q_out(q_out),
  .sticky_out(sticky_out)
);

// File: tb/shr_sticky_stage_test.sv
`timescale 1ns/1ps
module shr_sticky_stage_test;
  localparam int DW = 64;
  localparam int CW = 13;

  logic                 clk = 1'b0;
  logic                 rst, clr, sticky_en, long_mode;
  logic [DW-1:0]        r_in;
  logic signed [CW-1:0] shift_in;
  logic [DW-1:0]        q_out;
  logic                 sticky_out;

  int  n_checks = 0;
  int  n_fail   = 0;
  logic exp_flag = 1'b0;

  always #10 clk = ~clk;

  shr_sticky_stage uut (
    .clk(clk), .rst(rst), .clr(clr), .r_in(r_in), .shift_in(shift_in),
    .sticky_en(sticky_en), .long_mode(long_mode), .q_out(q_out),
    .sticky_out(sticky_out)
  );

  // Reference: explicit mask over the discarded window
  function automatic logic ref_lost(logic [DW-1:0] r, int sh, logic lm);
    int w;
    logic [DW-1:0] m;
    w = lm ? (29 - sh) : -sh;
    if (w <= 0) return 1'b0;
    m = (w >= DW) ? '1 : ((64'd1 << w) - 64'd1);
    return |(r & m);
  endfunction

  function automatic logic [DW-1:0] ref_shift(logic [DW-1:0] r, int sh);
    if (sh >= 0)   return r;
    if (-sh >= DW) return '0;
    return r >> (-sh);
  endfunction

  task automatic check(string req, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // Drive one operation at the falling edge, sample just after the next rising edge
  task automatic op(string req, logic [DW-1:0] r, int sh, logic en, logic lm, logic c);
    logic [DW-1:0] eq;
    @(negedge clk);
    r_in = r; shift_in = CW'(sh); sticky_en = en; long_mode = lm; clr = c;
    eq       = ref_shift(r, sh);
    exp_flag = (exp_flag & ~c) | (en & ref_lost(r, sh, lm));
    @(posedge clk); #2;
    check({req, " q"}, q_out, eq);
    check({req, " flag"}, DW'(sticky_out), DW'(exp_flag));
  endtask

  initial begin
    #3_000_000;
    n_checks++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    int unsigned dummy;
    dummy = $urandom(32'h5eed_1234);
    rst = 1'b1; clr = 1'b0; sticky_en = 1'b0; long_mode = 1'b0;
    r_in = '1; shift_in = -CW'(3);
    @(posedge clk); @(posedge clk); #2;
    check("R1 reset q", q_out, '0);
    check("R1 reset flag", DW'(sticky_out), '0);
    @(negedge clk); rst = 1'b0; exp_flag = 1'b0;

    // R5: window edge at count -1
    op("R5 bit1 not lost", 64'h2, -1, 1, 0, 1);
    op("R5 bit0 lost", 64'h1, -1, 1, 0, 1);
    op("R5 edge N=8 bit8", 64'h100, -8, 1, 0, 1);
    op("R5 edge N=8 bit7", 64'h80, -8, 1, 0, 1);
    // R6: long window
    op("R6 bit28 count0", 64'h1000_0000, 0, 1, 1, 1);
    op("R6 bit29 count0", 64'h2000_0000, 0, 1, 1, 1);
    op("R6 count29 no window", 64'hFFFF, 29, 1, 1, 1);
    op("R6 count28 bit0", 64'h1, 28, 1, 1, 1);
    // R7: clamp
    op("R7 msb at -64", 64'h8000_0000_0000_0000, -64, 1, 0, 1);
    op("R7 msb at -4000", 64'h8000_0000_0000_0000, -4000, 1, 0, 1);
    op("R7 zero operand", 64'h0, -4000, 1, 0, 1);
    op("R7 long wide", 64'h4000_0000_0000_0000, -40, 1, 1, 1);
    // R4 / R3
    op("R4 positive count", 64'hDEAD_BEEF_0123_4567, 5, 1, 0, 1);
    op("R3 shift 63", 64'hF000_0000_0000_0001, -63, 0, 0, 1);
    op("R3 shift 4", 64'h1234_5678_9ABC_DEF0, -4, 0, 0, 1);
    // R8 / R9 / R10
    op("R8 set", 64'h3, -2, 1, 0, 1);
    op("R8 hold", 64'h0, 0, 1, 0, 0);
    op("R9 enable low", 64'hFF, -8, 0, 0, 1);
    op("R9 enable low again", 64'hFF, -8, 0, 0, 0);
    op("R10 clear with loss", 64'h1, -1, 1, 0, 1);
    op("R10 clear alone", 64'h0, 0, 0, 0, 1);

    // R2: back-to-back random traffic, one result per cycle
    for (int i = 0; i < 3000; i++) begin
      logic [DW-1:0] r;
      int sh;
      case ($urandom % 4)
        0: r = 64'd1 << ($urandom % 64);
        1: r = '0;
        default: r = {$urandom, $urandom};
      endcase
      if ($urandom % 8 == 0) sh = -int'($urandom % 4000);
      else                   sh = int'($urandom % 120) - 80;
      op("R2 R3 R5 R6 random", r, sh, ($urandom % 4) != 0, $urandom % 2, ($urandom % 6) == 0);
    end

    // R1 again mid-run
    @(negedge clk); rst = 1'b1; r_in = '1; shift_in = '0;
    @(posedge clk); #2;
    check("R1 reset mid-run q", q_out, '0);
    check("R1 reset mid-run flag", DW'(sticky_out), '0);

    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule